// File: doc/BRIEF.md
# Guest entry sequencer

This block runs one request to switch the processor into a guest context. A request is either a first-time entry (launch) or a repeat entry (resume) on the same control structure. On an accepted start the block captures the request. It first checks locally that a current control structure exists and that the request type agrees with the structure's launch-state bit. It then asks four external checkers, one at a time, to do their work. These checkers are the basic checks, the control/host-state checks, the guest-state checks with state load, and the MSR load. After the MSR load succeeds, a fixed two-cycle tail updates the launch state and then fires an optional event injection.

Every request ends with one reporting cycle, marked by `done_o`. In that cycle the outcome appears as exactly one of four kinds:
- success;
- an ordinary fault raised by the basic checks;
- a fall-through failure, which reports through the zero or carry flag and the instruction-error field;
- a host fallback, which loads host state and records exit information.

A single-step trap request goes out only with a fall-through failure. A successful entry made from system-management mode, with the entry-to-SMM control clear, is also flagged as a return from that mode.

Top module: `gentry_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `phase_req_o` and every outcome output (flags, error write and codes, fault, host load, trap, launch set, inject, SMM return) are 0.
- R2: The phases are requested one at a time on `phase_req_o` in this order: bit 0 basic, bit 1 control/host, bit 2 guest state, bit 3 MSR load. A request stays asserted until a cycle with `phase_ack_i`=1, and the next phase is requested only after an ack with `phase_fail_i`=0.
- R3: When a current structure exists, two requests are illegal: a launch (`is_launch_i`=1) while `launched_i`=1, and a resume (`is_launch_i`=0) while `launched_i`=0. Either ends as a fall-through failure without requesting any phase. It sets `zf_set_o` and writes code LAUNCH_ERR (default 4) for a bad launch or RESUME_ERR (default 5) for a bad resume.
- R4: With `ctl_present_i`=0 the request ends as a fall-through failure without requesting any phase. It sets `cf_set_o`, leaves `zf_set_o` at 0, and makes no error write.
- R5: A basic-phase failure acked with `phase_fault_i`=1 reports `fault_o`=1 with no flag, no error write and no trap. `phase_fault_i` has no effect in any other phase.
- R6: A basic-phase failure without fault, or any control/host failure, is a fall-through. With a current structure it sets `zf_set_o`, pulses `err_wr_o` with `err_code_o` equal to the `phase_code_i` of the failing ack, and requests no later phase.
- R7: A guest-state or MSR-load failure reports `host_load_o`=1 with `exit_info_o` equal to the failing code. It raises no flag, no error write, no trap and no launch set, and requests no later phase.
- R8: `step_trap_o` is 1 in the done cycle only for a fall-through failure (R3, R4, R6) with `trap_flag_i`=1 at start. It is never raised for a fault, a host fallback or a success.
- R9: `launch_set_o` pulses for one cycle, two cycles before `done_o`, only for a launch whose MSR load succeeded. It never pulses for a resume or for any failure.
- R10: On success `inject_o` pulses in the cycle after the launch-state cycle and one cycle before `done_o`, only if `inject_pending_i`=1 at start.
- R11: `smm_return_o` is 1 in the done cycle of a successful entry only if `in_smm_i`=1 and `smm_entry_ctl_i`=0 at start.
- R12: `done_o` is a single-cycle pulse, exactly one per accepted start. Request inputs are captured at the accepted start. `start_i` and input changes while `busy_o`=1 have no effect, and the block is idle with no phase requested afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a request (accepted while idle) |
| is_launch_i | input | 1 | 1 = launch, 0 = resume |
| ctl_present_i | input | 1 | A current control structure exists |
| launched_i | input | 1 | Launch-state bit of the current structure |
| trap_flag_i | input | 1 | Single-step trap flag of the caller |
| in_smm_i | input | 1 | Request issued in system-management mode |
| smm_entry_ctl_i | input | 1 | Entry-to-SMM control |
| inject_pending_i | input | 1 | An event is to be injected on success |
| phase_req_o | output | 4 | One-hot phase request (bit0 basic .. bit3 MSR) |
| phase_ack_i | input | 1 | Responder finished the requested phase |
| phase_fail_i | input | 1 | Phase failed (valid with ack) |
| phase_fault_i | input | 1 | Basic-phase failure is an ordinary fault |
| phase_code_i | input | ERR_W | Error code of the failing phase |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Single-cycle completion strobe |
| zf_set_o | output | 1 | Set zero flag (fall-through, structure present) |
| cf_set_o | output | 1 | Set carry flag (fall-through, no structure) |
| err_wr_o | output | 1 | Write the instruction-error field |
| err_code_o | output | ERR_W | Value for the instruction-error field |
| fault_o | output | 1 | Ordinary fault to deliver |
| host_load_o | output | 1 | Fall back to host state |
| exit_info_o | output | ERR_W | Exit information for host fallback |
| step_trap_o | output | 1 | Single-step debug trap request |
| launch_set_o | output | 1 | Mark the structure as launched |
| inject_o | output | 1 | Inject the pending event |
| smm_return_o | output | 1 | Entry returns from system-management mode |

## Verification
The assertions check these properties on every cycle:
- `phase_req_o` is one-hot and holds until ack;
- phases advance by one only on a passing ack;
- any failing ack ends the sequence;
- the zero and carry flags never appear together;
- an error write, a trap or a fault never coexists with the wrong outcome kind;
- injection always follows the launch-state cycle, and `done_o` never lasts two cycles.

Only the bench scenarios can show the rest:
- the error codes that appear at the ports;
- the launch state is set for launches and never for resumes;
- the trap goes out for fall-through failures but not for faults, host fallbacks or successes;
- SMM-return flagging;
- a slow responder;
- a start pulse with changed inputs during a busy request leaves the captured request untouched.

// File: rtl/gentry_pkg.sv
package gentry_pkg;
  localparam int NUM_PH   = 4;
  localparam int PH_IDX_W = $clog2(NUM_PH);

  // phase order is behaviour: responders decode these bit positions
  localparam logic [PH_IDX_W-1:0] PH_BASIC   = PH_IDX_W'(0);
  localparam logic [PH_IDX_W-1:0] PH_CTLHOST = PH_IDX_W'(1);
  localparam logic [PH_IDX_W-1:0] PH_GUEST   = PH_IDX_W'(2);
  localparam logic [PH_IDX_W-1:0] PH_MSR     = PH_IDX_W'(3);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PHASE, ST_LSTATE, ST_INJECT, ST_REPORT
  } st_e;

  typedef enum logic [1:0] {
    OC_OK, OC_FAULT, OC_FALL, OC_HOST
  } oc_e;

  typedef struct packed {
    logic launch;
    logic ctl;
    logic trap;
    logic smm_ret;
    logic inject;
  } req_t;
endpackage

// File: rtl/gentry_precheck.sv
module gentry_precheck #(
  parameter int ERR_W      = 8,
  parameter int LAUNCH_ERR = 4,
  parameter int RESUME_ERR = 5
) (
  input  logic             ctl_present_i,
  input  logic             is_launch_i,
  input  logic             launched_i,
  output logic             fail_o,
  output logic [ERR_W-1:0] code_o
);
  always_comb begin
    fail_o = 1'b0;
    code_o = '0;
    if (!ctl_present_i) begin
      fail_o = 1'b1;
    end else if (is_launch_i && launched_i) begin
      fail_o = 1'b1;
      code_o = ERR_W'(LAUNCH_ERR);
    end else if (!is_launch_i && !launched_i) begin
      fail_o = 1'b1;
      code_o = ERR_W'(RESUME_ERR);
    end
  end
endmodule

// File: rtl/gentry_classify.sv
module gentry_classify
  import gentry_pkg::*;
(
  input  logic [PH_IDX_W-1:0] idx_i,
  input  logic                fault_i,
  output oc_e                 cls_o
);
  always_comb begin
    case (idx_i)
      PH_BASIC:   cls_o = fault_i ? OC_FAULT : OC_FALL;
      PH_CTLHOST: cls_o = OC_FALL;
      default:    cls_o = OC_HOST;  // guest state, MSR load
    endcase
  end
endmodule

// File: rtl/gentry_ctl.sv
module gentry_ctl
  import gentry_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  req_t                req_i,
  input  logic                pre_fail_i,
  input  logic [ERR_W-1:0]    pre_code_i,
  input  logic                ack_i,
  input  logic                fail_i,
  input  logic [ERR_W-1:0]    code_i,
  input  oc_e                 ph_cls_i,
  output st_e                 state_o,
  output logic [PH_IDX_W-1:0] idx_o,
  output req_t                req_q_o,
  output oc_e                 cls_o,
  output logic [ERR_W-1:0]    code_o
);
  localparam logic [PH_IDX_W-1:0] LAST_PH = PH_IDX_W'(NUM_PH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      idx_o   <= '0;
      req_q_o <= '0;
      cls_o   <= OC_OK;
      code_o  <= '0;
    end else begin
      case (state_o)
        ST_IDLE: if (start_i) begin
          req_q_o <= req_i;
          idx_o   <= PH_BASIC;
          if (pre_fail_i) begin
            cls_o   <= OC_FALL;
            code_o  <= pre_code_i;
            state_o <= ST_REPORT;
          end else begin
            state_o <= ST_PHASE;
          end
        end
        ST_PHASE: if (ack_i) begin
          if (fail_i) begin
            cls_o   <= ph_cls_i;
            code_o  <= code_i;
            state_o <= ST_REPORT;
          end else if (idx_o == LAST_PH) begin
            cls_o   <= OC_OK;
            code_o  <= '0;
            state_o <= ST_LSTATE;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
        ST_LSTATE: state_o <= ST_INJECT;
        ST_INJECT: state_o <= ST_REPORT;
        ST_REPORT: state_o <= ST_IDLE;
        default:   state_o <= ST_IDLE;
      endcase
    end
  end

  // R2: a phase is held until acked
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PHASE && !ack_i) |=> (state_o == ST_PHASE && $stable(idx_o)));
  // R2: passing ack advances to the next phase in order
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PHASE && ack_i && !fail_i && idx_o != LAST_PH)
      |=> (state_o == ST_PHASE && idx_o == PH_IDX_W'($past(idx_o) + 1'b1)));
  // R6: any failing ack stops the sequence
  p_fail_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PHASE && ack_i && fail_i) |=> state_o == ST_REPORT);
  // R9: launch-state cycle follows a successful MSR load
  p_msr_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PHASE && ack_i && !fail_i && idx_o == LAST_PH) |=> state_o == ST_LSTATE);
  // R3: local legality failure skips all phases
  p_pre_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && start_i && pre_fail_i) |=> (state_o == ST_REPORT && cls_o == OC_FALL));
  // R12: captured request is frozen while busy
  p_latch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_IDLE) |=> $stable(req_q_o));
endmodule

// File: rtl/gentry_report.sv
module gentry_report
  import gentry_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  st_e                 state_i,
  input  logic [PH_IDX_W-1:0] idx_i,
  input  oc_e                 cls_i,
  input  logic [ERR_W-1:0]    code_i,
  input  req_t                req_q_i,
  input  logic                ack_i,
  output logic [NUM_PH-1:0]   phase_req_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                zf_set_o,
  output logic                cf_set_o,
  output logic                err_wr_o,
  output logic [ERR_W-1:0]    err_code_o,
  output logic                fault_o,
  output logic                host_load_o,
  output logic [ERR_W-1:0]    exit_info_o,
  output logic                step_trap_o,
  output logic                launch_set_o,
  output logic                inject_o,
  output logic                smm_return_o
);
  logic fall;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_req
    assign phase_req_o[g] = (state_i == ST_PHASE) && (idx_i == PH_IDX_W'(g));
  end

  assign busy_o       = (state_i != ST_IDLE);
  assign done_o       = (state_i == ST_REPORT);
  assign fall         = done_o && (cls_i == OC_FALL);
  assign zf_set_o     = fall && req_q_i.ctl;
  assign cf_set_o     = fall && !req_q_i.ctl;
  assign err_wr_o     = zf_set_o;
  assign err_code_o   = err_wr_o ? code_i : '0;
  assign fault_o      = done_o && (cls_i == OC_FAULT);
  assign host_load_o  = done_o && (cls_i == OC_HOST);
  assign exit_info_o  = host_load_o ? code_i : '0;
  assign step_trap_o  = fall && req_q_i.trap;
  assign launch_set_o = (state_i == ST_LSTATE) && req_q_i.launch;
  assign inject_o     = (state_i == ST_INJECT) && req_q_i.inject;
  assign smm_return_o = done_o && (cls_i == OC_OK) && req_q_i.smm_ret;

  p_req_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_req_o));
  p_req_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|phase_req_o && !ack_i) |=> $stable(phase_req_o));
  p_flag_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zf_set_o && cf_set_o));
  p_fault_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(zf_set_o || cf_set_o || err_wr_o || step_trap_o));
  p_host_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_load_o |-> !(zf_set_o || cf_set_o || err_wr_o || step_trap_o || smm_return_o));
  p_trap_ft_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_trap_o |-> (zf_set_o || cf_set_o));
  p_ls_then_inj_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_set_o |=> (state_i == ST_INJECT));
  p_inj_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |-> ($past(state_i) == ST_LSTATE));
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/gentry_seq.sv
module gentry_seq
  import gentry_pkg::*;
#(
  parameter int ERR_W      = 8,
  parameter int LAUNCH_ERR = 4,
  parameter int RESUME_ERR = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_launch_i,
  input  logic              ctl_present_i,
  input  logic              launched_i,
  input  logic              trap_flag_i,
  input  logic              in_smm_i,
  input  logic              smm_entry_ctl_i,
  input  logic              inject_pending_i,
  output logic [NUM_PH-1:0] phase_req_o,
  input  logic              phase_ack_i,
  input  logic              phase_fail_i,
  input  logic              phase_fault_i,
  input  logic [ERR_W-1:0]  phase_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              zf_set_o,
  output logic              cf_set_o,
  output logic              err_wr_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic              fault_o,
  output logic              host_load_o,
  output logic [ERR_W-1:0]  exit_info_o,
  output logic              step_trap_o,
  output logic              launch_set_o,
  output logic              inject_o,
  output logic              smm_return_o
);
  req_t                req_in, req_q;
  logic                pre_fail;
  logic [ERR_W-1:0]    pre_code, code_q;
  st_e                 state;
  logic [PH_IDX_W-1:0] idx;
  oc_e                 ph_cls, cls_q;

  always_comb begin
    req_in.launch  = is_launch_i;
    req_in.ctl     = ctl_present_i;
    req_in.trap    = trap_flag_i;
    req_in.smm_ret = in_smm_i && !smm_entry_ctl_i;
    req_in.inject  = inject_pending_i;
  end

  gentry_precheck #(
    .ERR_W(ERR_W), .LAUNCH_ERR(LAUNCH_ERR), .RESUME_ERR(RESUME_ERR)
  ) u_pre (
    .ctl_present_i (ctl_present_i),
    .is_launch_i   (is_launch_i),
    .launched_i    (launched_i),
    .fail_o        (pre_fail),
    .code_o        (pre_code)
  );

  gentry_classify u_cls (
    .idx_i   (idx),
    .fault_i (phase_fault_i),
    .cls_o   (ph_cls)
  );

  gentry_ctl #(.ERR_W(ERR_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .req_i      (req_in),
    .pre_fail_i (pre_fail),
    .pre_code_i (pre_code),
    .ack_i      (phase_ack_i),
    .fail_i     (phase_fail_i),
    .code_i     (phase_code_i),
    .ph_cls_i   (ph_cls),
    .state_o    (state),
    .idx_o      (idx),
    .req_q_o    (req_q),
    .cls_o      (cls_q),
    .code_o     (code_q)
  );

  gentry_report #(.ERR_W(ERR_W)) u_rep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .idx_i        (idx),
    .cls_i        (cls_q),
    .code_i       (code_q),
    .req_q_i      (req_q),
    .ack_i        (phase_ack_i),
    .phase_req_o  (phase_req_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .zf_set_o     (zf_set_o),
    .cf_set_o     (cf_set_o),
    .err_wr_o     (err_wr_o),
    .err_code_o   (err_code_o),
    .fault_o      (fault_o),
    .host_load_o  (host_load_o),
    .exit_info_o  (exit_info_o),
    .step_trap_o  (step_trap_o),
    .launch_set_o (launch_set_o),
    .inject_o     (inject_o),
    .smm_return_o (smm_return_o)
  );
endmodule

// File: tb/gentry_seq_tb_top.sv
`timescale 1ns/1ps
module gentry_seq_tb_top;
  localparam int ERR_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, is_launch_i = 0, ctl_present_i = 0, launched_i = 0;
  logic trap_flag_i = 0, in_smm_i = 0, smm_entry_ctl_i = 0, inject_pending_i = 0;
  logic [3:0] phase_req_o;
  logic phase_ack_i = 0, phase_fail_i = 0, phase_fault_i = 0;
  logic [ERR_W-1:0] phase_code_i = '0;
  logic busy_o, done_o, zf_set_o, cf_set_o, err_wr_o, fault_o, host_load_o;
  logic step_trap_o, launch_set_o, inject_o, smm_return_o;
  logic [ERR_W-1:0] err_code_o, exit_info_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  gentry_seq #(.ERR_W(ERR_W)) dut_i (.*);

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic t_reset_r1;
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "phase_req", int'(phase_req_o), 0);
    chk("R1", "outcomes", int'({zf_set_o, cf_set_o, err_wr_o, fault_o, host_load_o,
        step_trap_o, launch_set_o, inject_o, smm_return_o}), 0);
    chk("R1", "codes", int'({err_code_o, exit_info_o}), 0);
  endtask

  // fph: failing phase index, -1 for none
  task automatic run_entry(input string nm, input bit la, input bit ct, input bit ld,
                           input bit tr, input bit sm, input bit es, input bit ij,
                           input int fph, input bit flt, input int code,
                           input bit slow, input bit glitch);
    int seq[4];
    int nreq = 0, ls_n = 0, inj_n = 0, done_n = 0;
    int ls_c = -1, inj_c = -1, done_c = -1, cyc = 0;
    bit hold = 0, run = 1, order_bad = 0, quiet_bad = 0;
    int zf = 0, cf = 0, ew = 0, ec = 0, fo = 0, hl = 0, ei = 0, st = 0, sr = 0;
    int ecls, ecode, enreq;
    bit ok;
    string ft_tag;

    $display("scenario: %s", nm);
    @(negedge clk_i);
    is_launch_i = la; ctl_present_i = ct; launched_i = ld; trap_flag_i = tr;
    in_smm_i = sm; smm_entry_ctl_i = es; inject_pending_i = ij;
    start_i = 1;
    while (run && cyc < 60) begin
      @(negedge clk_i);
      cyc++;
      start_i = 0;
      if (glitch && cyc == 2) begin
        start_i = 1;
        is_launch_i = ~la; ctl_present_i = ~ct; trap_flag_i = ~tr;
        inject_pending_i = ~ij; in_smm_i = ~sm;
      end
      if ($countones(phase_req_o) > 1) order_bad = 1;
      if (phase_req_o != 0) begin
        if (slow && !hold) begin
          phase_ack_i = 0;
          hold = 1;
        end else begin
          int idx = 0;
          for (int i = 0; i < 4; i++) if (phase_req_o[i]) idx = i;
          hold = 0;
          phase_ack_i = 1;
          phase_fail_i = (idx == fph);
          phase_fault_i = flt;
          phase_code_i = ERR_W'(code);
          if (nreq < 4) seq[nreq] = idx;
          nreq++;
        end
      end else begin
        phase_ack_i = 0;
      end
      if (launch_set_o) begin ls_n++; ls_c = cyc; end
      if (inject_o) begin inj_n++; inj_c = cyc; end
      if (done_o) begin
        done_n++; done_c = cyc; run = 0;
        zf = zf_set_o; cf = cf_set_o; ew = err_wr_o; ec = err_code_o;
        fo = fault_o; hl = host_load_o; ei = exit_info_o; st = step_trap_o;
        sr = smm_return_o;
      end
    end
    phase_ack_i = 0; phase_fail_i = 0; phase_fault_i = 0; start_i = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      if (busy_o || done_o || phase_req_o != 0) quiet_bad = 1;
    end

    // expected outcome: 0 ok, 1 fault, 2 fall-through, 3 host
    if (!ct) begin
      ecls = 2; ecode = 0; enreq = 0; ft_tag = "R4";
    end else if (la == ld) begin
      ecls = 2; ecode = la ? 4 : 5; enreq = 0; ft_tag = "R3";
    end else if (fph < 0) begin
      ecls = 0; ecode = 0; enreq = 4; ft_tag = "R6";
    end else begin
      enreq = fph + 1; ecode = code; ft_tag = "R6";
      ecls = (fph == 0) ? (flt ? 1 : 2) : (fph == 1 ? 2 : 3);
    end
    ok = (ecls == 0);

    chk("R2", "phase count", nreq, enreq);
    for (int i = 0; i < 4 && i < nreq; i++) if (seq[i] != i) order_bad = 1;
    chk("R2", "phase order", int'(order_bad), 0);
    chk("R12", "done count", done_n, 1);
    chk("R12", "idle after done", int'(quiet_bad), 0);
    chk(ft_tag, "zf", zf, int'(ecls == 2 && ct));
    chk(ft_tag, "cf", cf, int'(ecls == 2 && !ct));
    chk(ft_tag, "err_wr", ew, int'(ecls == 2 && ct));
    chk(ft_tag, "err_code", ec, (ecls == 2 && ct) ? ecode : 0);
    chk("R5", "fault", fo, int'(ecls == 1));
    chk("R7", "host_load", hl, int'(ecls == 3));
    chk("R7", "exit_info", ei, (ecls == 3) ? ecode : 0);
    chk("R8", "step_trap", st, int'(ecls == 2 && tr));
    chk("R9", "launch_set count", ls_n, int'(ok && la));
    if (ok && la) chk("R9", "launch_set cycle", ls_c, done_c - 2);
    chk("R10", "inject count", inj_n, int'(ok && ij));
    if (ok && ij) chk("R10", "inject cycle", inj_c, done_c - 1);
    chk("R11", "smm_return", sr, int'(ok && sm && !es));
  endtask

  task automatic t_launch_ok_r9;      run_entry("launch ok", 1,1,0, 0,0,0,0, -1,0,0, 0,0); endtask
  task automatic t_resume_slow_r10;   run_entry("resume slow inject", 0,1,1, 0,0,0,1, -1,0,0, 1,0); endtask
  task automatic t_bad_launch_r3;     run_entry("launch when launched", 1,1,1, 0,0,0,0, -1,0,0, 0,0); endtask
  task automatic t_bad_resume_r3;     run_entry("resume when clear", 0,1,0, 1,0,0,0, -1,0,0, 0,0); endtask
  task automatic t_no_ctl_r4;         run_entry("no structure", 1,0,0, 1,0,0,1, -1,0,0, 0,0); endtask
  task automatic t_fault_r5;          run_entry("basic fault", 1,1,0, 1,0,0,0, 0,1,8'h33, 0,0); endtask
  task automatic t_basic_fail_r6;     run_entry("basic fail", 0,1,1, 1,0,0,0, 0,0,8'h21, 0,0); endtask
  task automatic t_ctl_fail_r6;       run_entry("ctl fail fault ignored", 1,1,0, 0,0,0,1, 1,1,8'h07, 1,0); endtask
  task automatic t_guest_fail_r7;     run_entry("guest fail", 0,1,1, 1,0,0,1, 2,0,8'h21, 0,0); endtask
  task automatic t_msr_fail_r7;       run_entry("msr fail launch", 1,1,0, 1,1,0,1, 3,1,8'h9c, 0,0); endtask
  task automatic t_smm_ret_r11;       run_entry("smm return", 1,1,0, 0,1,0,1, -1,0,0, 0,0); endtask
  task automatic t_smm_ctl_r11;       run_entry("smm with entry ctl", 0,1,1, 0,1,1,0, -1,0,0, 0,0); endtask
  task automatic t_glitch_r12;        run_entry("start while busy", 1,1,0, 0,0,0,1, -1,0,0, 1,1); endtask
  task automatic t_trap_ok_r8;        run_entry("trap on success", 0,1,1, 1,0,0,0, -1,0,0, 0,0); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset_r1();
    t_launch_ok_r9();
    t_resume_slow_r10();
    t_bad_launch_r3();
    t_bad_resume_r3();
    t_no_ctl_r4();
    t_fault_r5();
    t_basic_fail_r6();
    t_ctl_fail_r6();
    t_guest_fail_r7();
    t_msr_fail_r7();
    t_smm_ret_r11();
    t_smm_ctl_r11();
    t_glitch_r12();
    t_trap_ok_r8();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule